// File: doc/BRIEF.md
# Full-Bridge Leg Pair Gate Controller

This block turns two logic-level drive inputs, a sleep/inhibit input and a set of digital fault requests into four gate enables: one high-side and one low-side enable for each of two half-bridge legs. The two legs together form one full bridge, so a DC motor can be driven in either direction, braked with both low sides or both high sides, or left floating. A bipolar stepper phase can be driven the same way. The two drive inputs have opposite polarity. Tying them together to a single line therefore gives complementary drive of the two legs from one signal.

Every gate enable is a register. Each leg holds its own break-before-make counter, so a switch may turn on only after the opposite switch of that leg has been off for a programmable number of cycles. Faults come in as digital levels. Supply and thermal faults remove all drive while they are present, and drive resumes by itself when they clear. An overcurrent trip on a leg is latched, and only a sleep cycle on the inhibit input releases it. After inhibit rises, all enables stay low for a programmable wake delay.

Top module: `hbp_bridge_ctrl`

## Requirements
- R1: Leg 0 follows `drv_a` without inversion: `drv_a`=1 requests the leg 0 high side, and `drv_a`=0 requests the leg 0 low side.
- R2: Leg 1 follows `drv_b` with inversion: `drv_b`=1 requests the leg 1 low side, and `drv_b`=0 requests the leg 1 high side.
- R3: Input pairs (`drv_a`,`drv_b`) decode as follows. (0,1) turns on both low sides, and this is the brake-low default. (1,0) turns on both high sides. (0,0) gives leg 0 low and leg 1 high. (1,1) gives leg 0 high and leg 1 low.
- R4: While `inhibit` is sampled low, all four enables are 0 from the next clock edge on, whatever the other inputs are.
- R5: In one leg, the high-side enable and the low-side enable are never 1 in the same cycle.
- R6: When a leg changes from one switch to the other, both of its enables stay 0 for exactly DEAD_CYCLES cycles (default 4) before the new enable rises. A leg that has already been off for DEAD_CYCLES cycles turns on one edge after its request.
- R7: After `inhibit` rises, all enables stay 0 for WAKE_CYCLES edges (default 8). A leg whose dead time has already elapsed turns on at edge WAKE_CYCLES+1.
- R8: A 1 on `flt_uv`, `flt_ov` or `flt_ot` turns all enables to 0 at the next edge. Once every such fault is 0, drive resumes with no other action, subject to R6.
- R9: A 1 on `oc_trip[i]` turns off both enables of leg i at the same edge that samples it. Leg i then stays off whatever the drive inputs do, and the other leg is not affected.
- R10: A latched overcurrent on a leg is released only by `inhibit` going low. Drive returns after `inhibit` rises again and the wake delay of R7 has passed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| inhibit | input | 1 | 0 = sleep, all switches off |
| drv_a | input | 1 | Leg 0 drive input, non-inverting |
| drv_b | input | 1 | Leg 1 drive input, inverting |
| flt_uv | input | 1 | Undervoltage shutdown request |
| flt_ov | input | 1 | Overvoltage shutdown request |
| flt_ot | input | 1 | Overtemperature shutdown request |
| oc_trip | input | 2 | Per-leg overcurrent trip, bit i = leg i |
| hs_en | output | 2 | High-side gate enable, bit i = leg i |
| ls_en | output | 2 | Low-side gate enable, bit i = leg i |

## Verification
The assertions check the following on every cycle: no leg ever has both enables high, and no enable rises before its leg has been idle for the dead time. They also check that inhibit, supply faults and thermal faults clear the outputs one edge later, and that a latched overcurrent survives while inhibit stays high. Only the directed scenarios can show three things. The first is the full mapping of input pairs to bridge states, including tying the inputs together. The second is the exact edge on which drive returns after the wake delay and after a fault clears. The third is that a tripped leg stays dark through input changes while its partner keeps switching.

// File: rtl/hbp_pkg.sv
package hbp_pkg;
  localparam int LEGS = 2;

  typedef enum logic [1:0] {
    DRV_OFF  = 2'd0,
    DRV_HIGH = 2'd1,
    DRV_LOW  = 2'd2
  } drive_e;
endpackage

// File: rtl/hbp_wake_timer.sv
module hbp_wake_timer #(
  parameter int WAKE_CYCLES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic inhibit,
  output logic awake
);
  localparam int CW = $clog2(WAKE_CYCLES + 1);
  localparam logic [CW-1:0] LIMIT = CW'(WAKE_CYCLES);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (!inhibit) begin
      cnt_q <= '0;
    end else if (cnt_q != LIMIT) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign awake = inhibit && (cnt_q == LIMIT);

  // a fresh wake-up never permits drive on the first cycle
  assert_wake_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(inhibit) |-> !awake);
endmodule

// File: rtl/hbp_oc_latch.sv
module hbp_oc_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic inhibit,
  input  logic trip,
  output logic blocked
);
  logic latched_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latched_q <= 1'b0;
    end else if (!inhibit) begin
      latched_q <= 1'b0;
    end else if (trip) begin
      latched_q <= 1'b1;
    end
  end

  assign blocked = latched_q || trip;

  assert_oc_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (latched_q && inhibit) |=> latched_q);

  assert_oc_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !inhibit |=> !latched_q);
endmodule

// File: rtl/hbp_mode_decode.sv
module hbp_mode_decode
  import hbp_pkg::*;
(
  input  logic            drv_a,
  input  logic            drv_b,
  input  logic            allow,
  input  logic [LEGS-1:0] leg_block,
  output drive_e          leg_req [LEGS]
);
  drive_e raw [LEGS];

  always_comb begin
    raw[0] = drv_a ? DRV_HIGH : DRV_LOW;
    raw[1] = drv_b ? DRV_LOW  : DRV_HIGH;
  end

  for (genvar i = 0; i < LEGS; i++) begin : g_gate
    assign leg_req[i] = (allow && !leg_block[i]) ? raw[i] : DRV_OFF;
  end
endmodule

// File: rtl/hbp_deadtime_leg.sv
module hbp_deadtime_leg
  import hbp_pkg::*;
#(
  parameter int DEAD_CYCLES = 4
) (
  input  logic   clk,
  input  logic   rst_n,
  input  drive_e req,
  output logic   hs_q,
  output logic   ls_q
);
  localparam int CW = $clog2(DEAD_CYCLES + 1);
  localparam logic [CW-1:0] LIMIT = CW'(DEAD_CYCLES);

  logic [CW-1:0] idle_q;
  logic          idle_ok;

  assign idle_ok = ({1'b0, idle_q} + 1'b1) >= {1'b0, LIMIT};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idle_q <= '0;
    end else if (hs_q || ls_q) begin
      idle_q <= '0;
    end else if (idle_q != LIMIT) begin
      idle_q <= idle_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs_q <= 1'b0;
      ls_q <= 1'b0;
    end else begin
      unique case (req)
        DRV_HIGH: begin
          ls_q <= 1'b0;
          hs_q <= hs_q || (!ls_q && idle_ok);
        end
        DRV_LOW: begin
          hs_q <= 1'b0;
          ls_q <= ls_q || (!hs_q && idle_ok);
        end
        default: begin
          hs_q <= 1'b0;
          ls_q <= 1'b0;
        end
      endcase
    end
  end

  // independent run-length of cycles with the leg fully off
  logic [CW-1:0] chk_run_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chk_run_q <= '0;
    else if (hs_q || ls_q) chk_run_q <= '0;
    else if (chk_run_q != LIMIT) chk_run_q <= chk_run_q + 1'b1;
  end

  assert_no_overlap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(hs_q && ls_q));

  assert_dead_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(hs_q) || $rose(ls_q)) |-> ($past(chk_run_q) + 1'b1 >= LIMIT));
endmodule

// File: rtl/hbp_bridge_ctrl.sv
module hbp_bridge_ctrl
  import hbp_pkg::*;
#(
  parameter int DEAD_CYCLES = 4,
  parameter int WAKE_CYCLES = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       inhibit,
  input  logic       drv_a,
  input  logic       drv_b,
  input  logic       flt_uv,
  input  logic       flt_ov,
  input  logic       flt_ot,
  input  logic [1:0] oc_trip,
  output logic [1:0] hs_en,
  output logic [1:0] ls_en
);
  logic            awake;
  logic            global_flt;
  logic [LEGS-1:0] leg_block;
  drive_e          leg_req [LEGS];

  assign global_flt = flt_uv || flt_ov || flt_ot;

  hbp_wake_timer #(.WAKE_CYCLES(WAKE_CYCLES)) u_wake (
    .clk     (clk),
    .rst_n   (rst_n),
    .inhibit (inhibit),
    .awake   (awake)
  );

  hbp_mode_decode u_decode (
    .drv_a     (drv_a),
    .drv_b     (drv_b),
    .allow     (awake && !global_flt),
    .leg_block (leg_block),
    .leg_req   (leg_req)
  );

  for (genvar i = 0; i < LEGS; i++) begin : g_leg
    hbp_oc_latch u_oc (
      .clk     (clk),
      .rst_n   (rst_n),
      .inhibit (inhibit),
      .trip    (oc_trip[i]),
      .blocked (leg_block[i])
    );

    hbp_deadtime_leg #(.DEAD_CYCLES(DEAD_CYCLES)) u_leg (
      .clk   (clk),
      .rst_n (rst_n),
      .req   (leg_req[i]),
      .hs_q  (hs_en[i]),
      .ls_q  (ls_en[i])
    );

    assert_oc_cut_R9: assert property (@(posedge clk) disable iff (!rst_n)
      oc_trip[i] |=> (!hs_en[i] && !ls_en[i]));
  end

  assert_sleep_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !inhibit |=> (hs_en == 2'b00 && ls_en == 2'b00));

  assert_fault_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    global_flt |=> (hs_en == 2'b00 && ls_en == 2'b00));

  assert_wake_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(inhibit) |=> (hs_en == 2'b00 && ls_en == 2'b00));
endmodule

// File: tb/test_hbp_bridge_ctrl.sv
module test_hbp_bridge_ctrl;
  localparam int DEAD = 4;
  localparam int WAKE = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       inhibit = 1'b0;
  logic       drv_a = 1'b0;
  logic       drv_b = 1'b1;
  logic       flt_uv = 1'b0;
  logic       flt_ov = 1'b0;
  logic       flt_ot = 1'b0;
  logic [1:0] oc_trip = 2'b00;
  logic [1:0] hs_en;
  logic [1:0] ls_en;

  int nchk = 0;
  int nerr = 0;
  int overlap = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  hbp_bridge_ctrl #(.DEAD_CYCLES(DEAD), .WAKE_CYCLES(WAKE)) i_hbp_bridge_ctrl (
    .clk, .rst_n, .inhibit, .drv_a, .drv_b, .flt_uv, .flt_ov, .flt_ot,
    .oc_trip, .hs_en, .ls_en
  );

  // R5 monitor, sampled away from the edge
  always @(negedge clk) begin
    if (rst_n && ((hs_en & ls_en) != 2'b00)) overlap++;
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic expect_out(input string tag, input logic [1:0] ehs, input logic [1:0] els);
    nchk++;
    if (hs_en !== ehs || ls_en !== els) begin
      nerr++;
      $display("FAIL %s: hs=%b ls=%b expected hs=%b ls=%b", tag, hs_en, ls_en, ehs, els);
    end
  endtask

  task automatic set_pair(input logic a, input logic b);
    drv_a = a;
    drv_b = b;
  endtask

  task automatic t_reset_and_wake();
    step(3);
    rst_n = 1'b1;
    step(1);
    expect_out("R4 reset and sleep state", 2'b00, 2'b00);
    inhibit = 1'b1;
    step(WAKE);
    expect_out("R7 still off after wake delay", 2'b00, 2'b00);
    step(1);
    expect_out("R7/R3 brake-low on after wake delay", 2'b00, 2'b11);
  endtask

  task automatic t_truth_table();
    set_pair(1'b1, 1'b0);
    step(DEAD + 2);
    expect_out("R3 pair (1,0) brake high", 2'b11, 2'b00);
    set_pair(1'b0, 1'b0);
    step(DEAD + 2);
    expect_out("R1/R2 pair (0,0) leg0 low leg1 high", 2'b10, 2'b01);
    set_pair(1'b1, 1'b1);
    step(DEAD + 2);
    expect_out("R1/R2 pair (1,1) leg0 high leg1 low", 2'b01, 2'b10);
    set_pair(1'b0, 1'b1);
    step(DEAD + 2);
    expect_out("R3 pair (0,1) brake low", 2'b00, 2'b11);
  endtask

  task automatic t_tied_inputs();
    set_pair(1'b1, 1'b1);
    step(DEAD + 2);
    expect_out("R3 tied high two-phase", 2'b01, 2'b10);
    set_pair(1'b0, 1'b0);
    step(DEAD + 2);
    expect_out("R3 tied low two-phase", 2'b10, 2'b01);
  endtask

  task automatic t_deadtime();
    set_pair(1'b0, 1'b1);
    step(DEAD + 2);
    set_pair(1'b1, 1'b1);
    step(1);
    expect_out("R6 leg0 low side off first", 2'b00, 2'b10);
    step(DEAD - 1);
    expect_out("R6 leg0 gap still open", 2'b00, 2'b10);
    step(1);
    expect_out("R6 leg0 high side after dead time", 2'b01, 2'b10);
  endtask

  task automatic t_sleep();
    set_pair(1'b1, 1'b0);
    step(DEAD + 2);
    inhibit = 1'b0;
    step(1);
    expect_out("R4 sleep cuts drive", 2'b00, 2'b00);
    set_pair(1'b0, 1'b0);
    step(3);
    expect_out("R4 sleep ignores inputs", 2'b00, 2'b00);
    set_pair(1'b0, 1'b1);
    inhibit = 1'b1;
    step(WAKE + 1);
    expect_out("R7 wake after sleep", 2'b00, 2'b11);
  endtask

  task automatic t_fault(input int which);
    set_pair(1'b1, 1'b1);
    step(DEAD + 2);
    flt_uv = (which == 0);
    flt_ov = (which == 1);
    flt_ot = (which == 2);
    step(1);
    expect_out($sformatf("R8 fault %0d cuts drive", which), 2'b00, 2'b00);
    step(6);
    expect_out($sformatf("R8 fault %0d holds off", which), 2'b00, 2'b00);
    flt_uv = 1'b0;
    flt_ov = 1'b0;
    flt_ot = 1'b0;
    step(1);
    expect_out($sformatf("R8 fault %0d auto resume", which), 2'b01, 2'b10);
  endtask

  task automatic t_short_fault();
    flt_ot = 1'b1;
    step(1);
    flt_ot = 1'b0;
    expect_out("R8 short fault off", 2'b00, 2'b00);
    step(DEAD - 1);
    expect_out("R6/R8 resume waits dead time", 2'b00, 2'b00);
    step(1);
    expect_out("R6/R8 resume after dead time", 2'b01, 2'b10);
  endtask

  task automatic t_overcurrent();
    set_pair(1'b1, 1'b1);
    step(DEAD + 2);
    oc_trip = 2'b01;
    step(1);
    oc_trip = 2'b00;
    expect_out("R9 trip cuts leg0 same edge", 2'b00, 2'b10);
    set_pair(1'b0, 1'b0);
    step(DEAD + 2);
    expect_out("R9 leg0 stays off, leg1 switches", 2'b10, 2'b00);
    set_pair(1'b1, 1'b1);
    step(DEAD + 2);
    expect_out("R9 leg0 still off", 2'b00, 2'b10);
    inhibit = 1'b0;
    step(2);
    expect_out("R10 sleep during release", 2'b00, 2'b00);
    inhibit = 1'b1;
    step(WAKE);
    expect_out("R10 wake delay after release", 2'b00, 2'b00);
    step(1);
    expect_out("R10 leg0 drives again", 2'b01, 2'b10);
  endtask

  initial begin
    t_reset_and_wake();
    t_truth_table();
    t_tied_inputs();
    t_deadtime();
    t_sleep();
    for (int f = 0; f < 3; f++) t_fault(f);
    t_short_fault();
    t_overcurrent();
    nchk++;
    if (overlap != 0) begin
      nerr++;
      $display("FAIL R5 overlap cycles: actual %0d expected 0", overlap);
    end
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

  initial begin
    for (int c = 0; c < 100000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      nchk++;
      nerr++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
    end
  end
endmodule